// File: doc/BRIEF.md
# Receiver Control and Status Unit

This unit sits between a host bus and a serial word receiver. The host writes an 8-bit control word that sets the receive mode. It reads back an 8-bit status byte that reports whether data is waiting, whether an error has occurred, and whether a first unit has arrived. A select line chooses which side the host is talking to. When the select line is high, host writes go to the control word and host reads return the status byte. When it is low, host cycles go to the data port. On the data port this unit only counts reads.

The receiver reports three kinds of event: a byte completed, a word completed, and the error qualifiers for that word. A label filter supplies a match flag. From these inputs the unit drives the data-ready and first-character pins for byte-at-a-time and whole-word modes. It keeps sticky overwrite, parity and framing flags. It also applies a one-word data-ready block that clears itself. All inputs are single-cycle pulses or levels. There is no valid/ready handshake and no back-pressure: events that arrive while data is still unread are not stalled. Such events are recorded through the overwrite flag instead.

Top module: `rx_ctl_stat`

## Requirements
- R1: On master reset the control word is 0x25 (bit 2 receive enable, bit 5 parity enable, bit 6 clear so byte mode), and the status byte, `rx_rdy` and `first_char` are 0.
- R2: A host write with `host_sel` high loads `host_wdata` into the control word on the next edge. A write with `host_sel` low leaves the control word unchanged.
- R3: A host read with `host_sel` high clears status bits 3 (parity), 4 (overwrite) and 5 (framing), unless a new error sets the same bit in that cycle. The read does not alter bits 1 and 6.
- R4: While control bit 3 is set, no event raises data-ready. Bit 3 clears by itself at the next word completion while receive is enabled.
- R5: In byte mode (control bit 6 = 0), each accepted byte completion sets data-ready (status bit 1 and `rx_rdy`).
- R6: In word mode (control bit 6 = 1), an accepted word completion sets data-ready only when there is no framing error. When control bit 5 is set, it must also have no parity error.
- R7: `first_char` (mirrored in status bit 6) sets on the first byte after a word boundary in byte mode, and on a clean accepted word in word mode. Control bit 3 has no effect on it.
- R8: When control bit 7 and `label_pin` are both high and `label_hit` is low, byte and word events raise neither data-ready, `first_char` nor the error flags.
- R9: If data-ready is set, is not being cleared, and a new data-ready event arrives, status bit 4 sets.
- R10: A data-port read clears data-ready and `first_char`. In byte mode every read does so. In word mode only the BYTES_PER_WORD-th read since the word arrived does so. A new event in the same cycle takes priority.
- R11: An accepted word with `frame_err` sets status bit 5. An accepted word with `parity_err` while control bit 5 is set sets status bit 3. Both bits stay set until a status read.
- R12: With control bit 2 clear, receiver events change no status bit and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mreset | input | 1 | Synchronous master reset, active high |
| host_sel | input | 1 | 1 selects control/status, 0 selects data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| byte_done | input | 1 | Receiver finished a good byte |
| word_done | input | 1 | Receiver finished a word |
| frame_err | input | 1 | Framing error qualifier for word_done |
| parity_err | input | 1 | Parity error qualifier for word_done |
| label_hit | input | 1 | Label filter found a match for the current word |
| label_pin | input | 1 | Hardware enable for label filtering |
| ctl_word | output | 8 | Current control word, driving receiver modes |
| stat_byte | output | 8 | Status byte returned on status reads |
| rx_rdy | output | 1 | Data-ready pin |
| first_char | output | 1 | First-character pin |

## Verification
The bench builds the unit with BYTES_PER_WORD = 4. Word-mode readout therefore takes four data reads, so the partial reads that must leave data-ready set and the final read that clears it can both be observed. The control reset value is left at 0x25. The run starts in byte mode and reaches word mode, inhibit, label filtering and receiver-disable only through host writes.

// File: rtl/rx_cs_pkg.sv
package rx_cs_pkg;
  localparam int CB_RXEN  = 2;
  localparam int CB_INH   = 3;
  localparam int CB_PAREN = 5;
  localparam int CB_WIDE  = 6;
  localparam int CB_LBL   = 7;

  localparam int SB_RDY   = 1;
  localparam int SB_PERR  = 3;
  localparam int SB_OVR   = 4;
  localparam int SB_FERR  = 5;
  localparam int SB_FCHR  = 6;

  typedef struct packed {
    logic perr;
    logic ovr;
    logic ferr;
  } err_flags_t;
endpackage

// File: rtl/rx_ctl_reg.sv
module rx_ctl_reg #(
  parameter int          W       = 8,
  parameter logic [7:0]  CTL_RST = 8'h25
) (
  input  logic         clk,
  input  logic         mreset,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         word_end,
  output logic [W-1:0] ctl_q
);
  import rx_cs_pkg::*;

  always_ff @(posedge clk) begin
    if (mreset)                        ctl_q <= W'(CTL_RST);
    else if (wr_en)                    ctl_q <= wdata;
    else if (word_end && ctl_q[CB_INH]) ctl_q[CB_INH] <= 1'b0;
  end

  // R4
  inh_self_clear_chk: assert property (@(posedge clk) disable iff (mreset)
    (ctl_q[CB_INH] && word_end && !wr_en) |=> !ctl_q[CB_INH]);

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (mreset)
    (!wr_en && !word_end) |=> $stable(ctl_q));
endmodule

// File: rtl/rx_flag_core.sv
module rx_flag_core #(
  parameter int BYTES_PER_WORD = 4
) (
  input  logic clk,
  input  logic mreset,
  input  logic rx_en,
  input  logic wide,
  input  logic inh,
  input  logic accept,
  input  logic clean_word,
  input  logic byte_done,
  input  logic word_done,
  input  logic data_rd,
  output logic rdy_q,
  output logic fchar_q,
  output logic ovr_evt
);
  localparam int CW = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTES_PER_WORD - 1);

  logic          mid_word;
  logic [CW-1:0] rd_cnt;
  logic          set_rdy, set_fc, clr;

  always_comb begin
    if (wide) begin
      set_fc = clean_word && accept;
      clr    = data_rd && (rd_cnt == LAST);
    end else begin
      set_fc = byte_done && accept && !mid_word;
      clr    = data_rd;
    end
    set_rdy = (wide ? (clean_word && accept) : (byte_done && accept)) && !inh;
    ovr_evt = set_rdy && rdy_q && !clr;
  end

  always_ff @(posedge clk) begin
    if (mreset) begin
      mid_word <= 1'b0;
      rd_cnt   <= '0;
      rdy_q    <= 1'b0;
      fchar_q  <= 1'b0;
    end else begin
      if (word_done && rx_en)      mid_word <= 1'b0;
      else if (byte_done && rx_en) mid_word <= 1'b1;

      if (set_rdy)      rd_cnt <= '0;
      else if (data_rd) rd_cnt <= (rd_cnt == LAST) ? '0 : rd_cnt + 1'b1;

      if (set_rdy)  rdy_q <= 1'b1;
      else if (clr) rdy_q <= 1'b0;

      if (set_fc)   fchar_q <= 1'b1;
      else if (clr) fchar_q <= 1'b0;
    end
  end

  // R4
  rdy_inhibit_chk: assert property (@(posedge clk) disable iff (mreset)
    (inh && !rdy_q) |=> !rdy_q);

  // R12
  rdy_disabled_chk: assert property (@(posedge clk) disable iff (mreset)
    (!rx_en && !rdy_q) |=> !rdy_q);

  // R12
  fchar_disabled_chk: assert property (@(posedge clk) disable iff (mreset)
    (!rx_en && !fchar_q) |=> !fchar_q);
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags (
  input  logic                  clk,
  input  logic                  mreset,
  input  logic                  set_par,
  input  logic                  set_frm,
  input  logic                  set_ovr,
  input  logic                  rdy_in,
  input  logic                  clr,
  output rx_cs_pkg::err_flags_t flags_q
);
  always_ff @(posedge clk) begin
    if (mreset) begin
      flags_q <= '0;
    end else begin
      flags_q.perr <= set_par || (flags_q.perr && !clr);
      flags_q.ferr <= set_frm || (flags_q.ferr && !clr);
      flags_q.ovr  <= set_ovr || (flags_q.ovr  && !clr);
    end
  end

  // R9
  ovr_needs_rdy_chk: assert property (@(posedge clk) disable iff (mreset)
    $rose(flags_q.ovr) |-> $past(rdy_in));

  // R3
  perr_read_clear_chk: assert property (@(posedge clk) disable iff (mreset)
    (clr && !set_par) |=> !flags_q.perr);

  // R3
  ferr_read_clear_chk: assert property (@(posedge clk) disable iff (mreset)
    (clr && !set_frm) |=> !flags_q.ferr);
endmodule

// File: rtl/rx_ctl_stat.sv
module rx_ctl_stat #(
  parameter int         BYTES_PER_WORD = 4,
  parameter logic [7:0] CTL_RST        = 8'h25
) (
  input  logic       clk,
  input  logic       mreset,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  input  logic       byte_done,
  input  logic       word_done,
  input  logic       frame_err,
  input  logic       parity_err,
  input  logic       label_hit,
  input  logic       label_pin,
  output logic [7:0] ctl_word,
  output logic [7:0] stat_byte,
  output logic       rx_rdy,
  output logic       first_char
);
  import rx_cs_pkg::*;

  logic       rx_en, accept, clean_word, ovr_evt, rdy_q, fchar_q;
  err_flags_t flags;

  assign rx_en      = ctl_word[CB_RXEN];
  assign accept     = rx_en && !(ctl_word[CB_LBL] && label_pin && !label_hit);
  assign clean_word = word_done && !frame_err && !(ctl_word[CB_PAREN] && parity_err);

  rx_ctl_reg #(.W(8), .CTL_RST(CTL_RST)) u_ctl (
    .clk      (clk),
    .mreset   (mreset),
    .wr_en    (host_wr && host_sel),
    .wdata    (host_wdata),
    .word_end (word_done && rx_en),
    .ctl_q    (ctl_word)
  );

  rx_flag_core #(.BYTES_PER_WORD(BYTES_PER_WORD)) u_flags (
    .clk        (clk),
    .mreset     (mreset),
    .rx_en      (rx_en),
    .wide       (ctl_word[CB_WIDE]),
    .inh        (ctl_word[CB_INH]),
    .accept     (accept),
    .clean_word (clean_word),
    .byte_done  (byte_done),
    .word_done  (word_done),
    .data_rd    (host_rd && !host_sel),
    .rdy_q      (rdy_q),
    .fchar_q    (fchar_q),
    .ovr_evt    (ovr_evt)
  );

  rx_err_flags u_err (
    .clk     (clk),
    .mreset  (mreset),
    .set_par (word_done && accept && ctl_word[CB_PAREN] && parity_err),
    .set_frm (word_done && accept && frame_err),
    .set_ovr (ovr_evt),
    .rdy_in  (rdy_q),
    .clr     (host_rd && host_sel),
    .flags_q (flags)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[SB_RDY]  = rdy_q;
    stat_byte[SB_PERR] = flags.perr;
    stat_byte[SB_OVR]  = flags.ovr;
    stat_byte[SB_FERR] = flags.ferr;
    stat_byte[SB_FCHR] = fchar_q;
  end
  assign rx_rdy     = rdy_q;
  assign first_char = fchar_q;

  // R8
  label_block_chk: assert property (@(posedge clk) disable iff (mreset)
    (ctl_word[CB_LBL] && label_pin && !label_hit && !rx_rdy) |=> !rx_rdy);
endmodule

// File: tb/test_rx_ctl_stat.sv
`timescale 1ns/1ps
module test_rx_ctl_stat;
  localparam int BPW = 4;

  logic clk = 0, mreset = 1;
  logic host_sel = 0, host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0;
  logic byte_done = 0, word_done = 0, frame_err = 0, parity_err = 0;
  logic label_hit = 0, label_pin = 0;
  logic [7:0] ctl_word, stat_byte;
  logic rx_rdy, first_char;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rx_ctl_stat #(.BYTES_PER_WORD(BPW), .CTL_RST(8'h25)) i_rx_ctl_stat (
    .clk(clk), .mreset(mreset), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .byte_done(byte_done),
    .word_done(word_done), .frame_err(frame_err), .parity_err(parity_err),
    .label_hit(label_hit), .label_pin(label_pin), .ctl_word(ctl_word),
    .stat_byte(stat_byte), .rx_rdy(rx_rdy), .first_char(first_char));

  // Behavioural reference
  int m_ctl, m_rc;
  bit m_rdy, m_fc, m_ovr, m_perr, m_ferr, m_mid;

  always @(posedge clk) begin
    if (mreset) begin
      m_ctl = 'h25; m_rc = 0;
      m_rdy = 0; m_fc = 0; m_ovr = 0; m_perr = 0; m_ferr = 0; m_mid = 0;
    end else begin
      bit en, ok, wide, pe, inh, drd, srd, clean, sr, sf, cl, sp, sfr, so;
      en    = m_ctl[2];
      wide  = m_ctl[6];
      pe    = m_ctl[5];
      inh   = m_ctl[3];
      ok    = en && !(m_ctl[7] && label_pin && !label_hit);
      drd   = host_rd && !host_sel;
      srd   = host_rd && host_sel;
      clean = word_done && !frame_err && !(pe && parity_err);
      sr    = (wide ? (clean && ok) : (byte_done && ok)) && !inh;
      sf    = wide ? (clean && ok) : (byte_done && ok && !m_mid);
      cl    = drd && (!wide || m_rc == BPW - 1);
      sp    = word_done && ok && pe && parity_err;
      sfr   = word_done && ok && frame_err;
      so    = sr && m_rdy && !cl;
      m_perr = sp  || (m_perr && !srd);
      m_ferr = sfr || (m_ferr && !srd);
      m_ovr  = so  || (m_ovr  && !srd);
      if (sr) m_rc = 0; else if (drd) m_rc = (m_rc == BPW - 1) ? 0 : m_rc + 1;
      if (sr) m_rdy = 1; else if (cl) m_rdy = 0;
      if (sf) m_fc = 1;  else if (cl) m_fc = 0;
      if (word_done && en) m_mid = 0; else if (byte_done && en) m_mid = 1;
      if (host_wr && host_sel) m_ctl = host_wdata;
      else if (word_done && en && inh) m_ctl[3] = 0;
    end
  end

  function automatic logic [7:0] m_stat();
    logic [7:0] s = 0;
    s[1] = m_rdy; s[3] = m_perr; s[4] = m_ovr; s[5] = m_ferr; s[6] = m_fc;
    return s;
  endfunction

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!mreset) begin
      checks++;
      if (ctl_word !== m_ctl[7:0] || stat_byte !== m_stat() ||
          rx_rdy !== m_rdy || first_char !== m_fc) begin
        fails++;
        $display("FAIL R2/R3/R5/R6/R9/R10/R11 cycle compare: ctl=%h stat=%h rdy=%b fc=%b expected ctl=%h stat=%h rdy=%b fc=%b",
                 ctl_word, stat_byte, rx_rdy, first_char, m_ctl[7:0], m_stat(), m_rdy, m_fc);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    host_wr = 0; host_rd = 0; host_sel = 0;
    byte_done = 0; word_done = 0; frame_err = 0; parity_err = 0;
  endtask

  task automatic wr_reg(input logic [7:0] v, input bit sel = 1);
    host_sel = sel; host_wr = 1; host_wdata = v; tick();
  endtask
  task automatic rd_stat(); host_sel = 1; host_rd = 1; tick(); endtask
  task automatic rd_data(); host_sel = 0; host_rd = 1; tick(); endtask
  task automatic byte_ev(); byte_done = 1; tick(); endtask
  task automatic word_ev(input bit fe = 0, input bit pe = 0);
    word_done = 1; frame_err = fe; parity_err = pe; tick();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); mreset = 0; @(negedge clk);
    // R1 reset state
    chk(ctl_word == 8'h25, "R1 ctl reset", ctl_word, 8'h25);
    chk(stat_byte == 0 && !rx_rdy && !first_char, "R1 status reset", stat_byte, 0);

    // R2 write with select low ignored, with select high taken
    wr_reg(8'hFF, 0);
    chk(ctl_word == 8'h25, "R2 data-port write ignored", ctl_word, 8'h25);
    wr_reg(8'h25);
    chk(ctl_word == 8'h25, "R2 ctl write", ctl_word, 8'h25);

    // R5 R7 byte mode, R9 overwrite
    byte_ev();
    chk(rx_rdy && first_char, "R5 byte rdy / R7 first byte", {rx_rdy, first_char}, 2'b11);
    byte_ev();
    chk(stat_byte[4], "R9 overwrite", stat_byte, 8'h52);
    rd_data();
    chk(!rx_rdy && !first_char, "R10 byte-mode read clears", {rx_rdy, first_char}, 0);
    byte_ev();
    chk(rx_rdy && !first_char, "R7 only first byte flags", {rx_rdy, first_char}, 2'b10);
    rd_stat();
    chk(!stat_byte[4] && stat_byte[1], "R3 status read clears overwrite only", stat_byte, 8'h02);
    rd_data(); word_ev();

    // R6 R10 word mode
    wr_reg(8'h65);
    word_ev();
    chk(rx_rdy && first_char, "R6 clean word", {rx_rdy, first_char}, 2'b11);
    for (int i = 0; i < BPW - 1; i++) rd_data();
    chk(rx_rdy, "R10 partial reads keep rdy", rx_rdy, 1);
    rd_data();
    chk(!rx_rdy && !first_char, "R10 last read clears", rx_rdy, 0);

    // R11 errors
    word_ev(0, 1);
    chk(stat_byte == 8'h08, "R11 parity error", stat_byte, 8'h08);
    word_ev(1, 0);
    chk(stat_byte == 8'h28, "R11 framing error", stat_byte, 8'h28);
    rd_stat();
    chk(stat_byte == 0, "R3 read clears errors", stat_byte, 0);
    wr_reg(8'h45);
    word_ev(0, 1);
    chk(rx_rdy && stat_byte[3] == 0, "R6 parity ignored when disabled", stat_byte, 8'h42);
    for (int i = 0; i < BPW; i++) rd_data();

    // R4 inhibit one word, R7 unaffected
    wr_reg(8'h6D);
    word_ev();
    chk(!rx_rdy && first_char, "R4 inhibited / R7 fchar", {rx_rdy, first_char}, 2'b01);
    chk(ctl_word[3] == 0, "R4 self clear", ctl_word, 8'h65);
    word_ev();
    chk(rx_rdy, "R4 next word rdy", rx_rdy, 1);
    for (int i = 0; i < BPW; i++) rd_data();

    // R8 label filter
    wr_reg(8'hE5); label_pin = 1; label_hit = 0;
    word_ev(1, 0);
    chk(stat_byte == 0, "R8 mismatch suppressed", stat_byte, 0);
    label_hit = 1;
    word_ev();
    chk(rx_rdy, "R8 match accepted", rx_rdy, 1);
    for (int i = 0; i < BPW; i++) rd_data();
    label_pin = 0;

    // R12 receiver disabled
    wr_reg(8'h61);
    word_ev(1, 1); byte_ev();
    chk(stat_byte == 0 && !rx_rdy && !first_char, "R12 disabled", stat_byte, 0);

    repeat (3) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule